// File: doc/BRIEF.md
# Card Access Strobe Timing Sequencer

This block times a single card access as three back-to-back phases: an address setup interval, an interval with the access strobe asserted, and a hold interval. The caller supplies the access time it needs, already converted to bus clock cycles, and says whether the access is I/O or memory. The block inflates that cycle count by a fixed safety margin. It caps the result just under the bus-monitor timeout and divides it into the three phase lengths. The phase lengths are visible on output ports.

A one-cycle start pulse latches the three lengths and launches the sequence. Busy stays high while the phases run. The strobe output is high only during the strobe phase. A phase of length zero is skipped without an idle cycle. A one-cycle done pulse marks the end of the access. A start that arrives while a sequence is running is ignored.

Top module: `card_strobe_seq`

## Requirements
- R1: The total count is floor(base × MARGIN_PCT / 100) cycles, with MARGIN_PCT = 180 by default. Here base is the request on `req_cyc`.
- R2: When the scaled count is at or above LIMIT (default 60), the total becomes LIMIT − 1.
- R3: `hold_cyc` = total/7 and `strobe_cyc` = (5 × total)/7, both rounded down. `setup_cyc` = total − hold − strobe, so the rounding remainder goes to setup. These fields change combinationally with the inputs.
- R4: A request of 0 is replaced before scaling. It becomes IO_DFLT (13) cycles when `is_io` = 1 and MEM_DFLT (5) cycles when `is_io` = 0.
- R5: A start seen at a clock edge while idle raises busy in the next cycle. Busy then stays high for exactly setup + strobe + hold cycles.
- R6: Strobe is high only during the strobe phase. That phase starts after exactly `setup_cyc` busy cycles and lasts `strobe_cyc` cycles.
- R7: A phase of length zero is skipped. No cycle is spent in it, and a total of 1 gives a single busy cycle with no strobe.
- R8: Done is high for exactly one cycle, in the cycle right after the last busy cycle, and busy is low in that cycle.
- R9: A start asserted while busy has no effect. The running sequence keeps its length, and no new sequence follows it.
- R10: The phase lengths are latched at start. A change on `req_cyc` or `is_io` during a sequence does not change its timing.
- R11: While `rst_n` is low and after its release, busy, strobe and done are low until a start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled at the rising edge |
| is_io | input | 1 | 1 selects the I/O default for a zero request, 0 the memory default |
| req_cyc | input | REQ_W (8) | Requested access time in bus cycles, 0 meaning default |
| strobe | output | 1 | Access strobe, high during the strobe phase |
| busy | output | 1 | High while any phase runs |
| done | output | 1 | One-cycle pulse after the hold phase |
| setup_cyc | output | PW (6) | Computed setup length |
| strobe_cyc | output | PW (6) | Computed strobe length |
| hold_cyc | output | PW (6) | Computed hold length |

## Verification
The three length fields are combinational, so they are checked in the same cycle the request is applied. Sequence outputs are counted from the first cycle after the edge that sees start, which is index 0. Busy is expected high at indices 0 through total − 1. Strobe is expected to rise at index `setup_cyc` and to stay high for `strobe_cyc` cycles. Done is expected at index total only.

All inputs change at the falling clock edge, and every sample is taken at a falling edge before any input changes. A poked start or a request change in mid-sequence is applied the same way, and the run is then compared against the length latched at launch.

// File: rtl/cstrb_pkg.sv
package cstrb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STRB  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/cstrb_timing_calc.sv
module cstrb_timing_calc #(
  parameter int REQ_W      = 8,
  parameter int PW         = 6,
  parameter int MARGIN_PCT = 180,
  parameter int LIMIT      = 60,
  parameter int IO_DFLT    = 13,
  parameter int MEM_DFLT   = 5
) (
  input  logic [REQ_W-1:0] req_cyc,
  input  logic             is_io,
  output logic [PW-1:0]    setup_cyc,
  output logic [PW-1:0]    strobe_cyc,
  output logic [PW-1:0]    hold_cyc
);
  logic [31:0] base, scaled, total, h_part, s_part;

  always_comb begin
    // zero request falls back to a per-kind default before scaling
    if (req_cyc == '0) base = is_io ? 32'(IO_DFLT) : 32'(MEM_DFLT);
    else               base = 32'(req_cyc);
    scaled = (base * 32'(MARGIN_PCT)) / 32'd100;
    // stay strictly below the bus-monitor timeout
    total  = (scaled >= 32'(LIMIT)) ? 32'(LIMIT - 1) : scaled;
    h_part = total / 32'd7;
    s_part = (total * 32'd5) / 32'd7;
    hold_cyc   = PW'(h_part);
    strobe_cyc = PW'(s_part);
    setup_cyc  = PW'(total - h_part - s_part);
  end
endmodule

// File: rtl/cstrb_phase_seq.sv
module cstrb_phase_seq
  import cstrb_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] setup_cyc,
  input  logic [PW-1:0] strobe_cyc,
  input  logic [PW-1:0] hold_cyc,
  output logic          strobe,
  output logic          busy,
  output logic          done
);
  phase_e        phase_q, phase_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] strb_len_q, hold_len_q;
  logic          done_q, done_d;
  logic          lat_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    lat_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          lat_en = 1'b1;
          if (setup_cyc != '0) begin
            phase_d = PH_SETUP; cnt_d = setup_cyc;
          end else if (strobe_cyc != '0) begin
            phase_d = PH_STRB;  cnt_d = strobe_cyc;
          end else if (hold_cyc != '0) begin
            phase_d = PH_HOLD;  cnt_d = hold_cyc;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == PW'(1)) begin
          if (strb_len_q != '0) begin
            phase_d = PH_STRB; cnt_d = strb_len_q;
          end else if (hold_len_q != '0) begin
            phase_d = PH_HOLD; cnt_d = hold_len_q;
          end else begin
            phase_d = PH_IDLE; done_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - PW'(1);
        end
      end
      PH_STRB: begin
        if (cnt_q == PW'(1)) begin
          if (hold_len_q != '0) begin
            phase_d = PH_HOLD; cnt_d = hold_len_q;
          end else begin
            phase_d = PH_IDLE; done_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - PW'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == PW'(1)) begin
          phase_d = PH_IDLE; done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - PW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_len_q <= '0;
      hold_len_q <= '0;
    end else if (lat_en) begin
      strb_len_q <= strobe_cyc;
      hold_len_q <= hold_cyc;
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign strobe = (phase_q == PH_STRB);
  assign done   = done_q;
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq #(
  parameter int REQ_W      = 8,
  parameter int MARGIN_PCT = 180,
  parameter int LIMIT      = 60,
  parameter int IO_DFLT    = 13,
  parameter int MEM_DFLT   = 5,
  parameter int PW         = $clog2(LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_io,
  input  logic [REQ_W-1:0] req_cyc,
  output logic             strobe,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    setup_cyc,
  output logic [PW-1:0]    strobe_cyc,
  output logic [PW-1:0]    hold_cyc
);
  cstrb_timing_calc #(
    .REQ_W(REQ_W), .PW(PW), .MARGIN_PCT(MARGIN_PCT), .LIMIT(LIMIT),
    .IO_DFLT(IO_DFLT), .MEM_DFLT(MEM_DFLT)
  ) u_calc (
    .req_cyc   (req_cyc),
    .is_io     (is_io),
    .setup_cyc (setup_cyc),
    .strobe_cyc(strobe_cyc),
    .hold_cyc  (hold_cyc)
  );

  cstrb_phase_seq #(.PW(PW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .setup_cyc (setup_cyc),
    .strobe_cyc(strobe_cyc),
    .hold_cyc  (hold_cyc),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: rtl/cstrb_checker.sv
module cstrb_checker #(
  parameter int PW    = 6,
  parameter int LIMIT = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          strobe,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] setup_cyc,
  input logic [PW-1:0] strobe_cyc,
  input logic [PW-1:0] hold_cyc
);
  p_total_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(setup_cyc) + 32'(strobe_cyc) + 32'(hold_cyc)) < 32'(LIMIT));

  p_split_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cyc <= setup_cyc) && (hold_cyc <= strobe_cyc));

  p_strobe_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind card_strobe_seq cstrb_checker #(.PW(PW), .LIMIT(LIMIT)) u_cstrb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .strobe    (strobe),
  .busy      (busy),
  .done      (done),
  .setup_cyc (setup_cyc),
  .strobe_cyc(strobe_cyc),
  .hold_cyc  (hold_cyc)
);

// File: tb/test_card_strobe_seq.sv
module test_card_strobe_seq;
  localparam int PW = 6;
  localparam int NV = 10;
  // {req, is_io, setup, strobe, hold}
  localparam logic [39:0] VEC [NV] = '{
    {8'd10,  8'd0, 8'd4, 8'd12, 8'd2},
    {8'd0,   8'd1, 8'd4, 8'd16, 8'd3},
    {8'd0,   8'd0, 8'd2, 8'd6,  8'd1},
    {8'd1,   8'd0, 8'd1, 8'd0,  8'd0},
    {8'd3,   8'd0, 8'd2, 8'd3,  8'd0},
    {8'd33,  8'd1, 8'd9, 8'd42, 8'd8},
    {8'd34,  8'd0, 8'd9, 8'd42, 8'd8},
    {8'd200, 8'd1, 8'd9, 8'd42, 8'd8},
    {8'd2,   8'd0, 8'd1, 8'd2,  8'd0},
    {8'd4,   8'd1, 8'd1, 8'd5,  8'd1}
  };

  logic clk = 1'b0;
  logic rst_n, start, is_io;
  logic [7:0] req_cyc;
  logic strobe, busy, done;
  logic [PW-1:0] setup_cyc, strobe_cyc, hold_cyc;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  card_strobe_seq i_card_strobe_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_io(is_io), .req_cyc(req_cyc),
    .strobe(strobe), .busy(busy), .done(done),
    .setup_cyc(setup_cyc), .strobe_cyc(strobe_cyc), .hold_cyc(hold_cyc)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Launch one sequence and measure it. poke_idx >= 0 applies a start pulse
  // and/or a new request at that index, while the sequence runs.
  task automatic run_seq(input int s, input int t, input int h, input int poke_idx,
                         input bit poke_start, input bit poke_req);
    int c = s + t + h;
    int busy_n = 0, strb_n = 0, strb_first = -1, done_idx = -1, done_n = 0;
    start = 1'b1;
    @(posedge clk);
    for (int i = 0; i <= c + 3; i++) begin
      @(negedge clk);
      if (busy) busy_n++;
      if (strobe) begin
        strb_n++;
        if (strb_first < 0) strb_first = i;
      end
      if (done) begin
        done_n++;
        done_idx = i;
      end
      if (i == 0) start = 1'b0;
      if (i == poke_idx) begin
        if (poke_start) start = 1'b1;
        if (poke_req) begin req_cyc = 8'd200; is_io = ~is_io; end
      end
      if (i == poke_idx + 1) start = 1'b0;
    end
    check("R5 busy cycles", busy_n, c);
    check("R6 strobe cycles", strb_n, t);
    if (t > 0) check("R6 strobe start index", strb_first, s);
    check("R8/R7 done index", done_idx, c);
    check("R8 done pulses", done_n, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_io = 1'b0; req_cyc = 8'd10;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 busy in reset", int'(busy), 0);
    check("R11 strobe in reset", int'(strobe), 0);
    check("R11 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 busy after release", int'(busy), 0);

    // Table walk: R1, R2, R3, R4 on fields; R5..R8 on the run
    for (int k = 0; k < NV; k++) begin
      req_cyc = VEC[k][39:32];
      is_io   = VEC[k][24];
      #1;
      check("R1/R3/R4 setup", int'(setup_cyc), int'(VEC[k][23:16]));
      check("R1/R3/R2 strobe len", int'(strobe_cyc), int'(VEC[k][15:8]));
      check("R1/R3 hold", int'(hold_cyc), int'(VEC[k][7:0]));
      run_seq(int'(VEC[k][23:16]), int'(VEC[k][15:8]), int'(VEC[k][7:0]), -1, 1'b0, 1'b0);
    end

    // R9: start during busy is ignored, and no second run follows
    req_cyc = 8'd10; is_io = 1'b0;
    @(negedge clk);
    run_seq(4, 12, 2, 5, 1'b1, 1'b0);
    check("R9 no relaunch", int'(busy), 0);

    // R10: request changes mid-run do not alter the latched timing
    req_cyc = 8'd10; is_io = 1'b0;
    @(negedge clk);
    run_seq(4, 12, 2, 2, 1'b0, 1'b1);
    check("R10 fields follow new request", int'(strobe_cyc), 42);

    // R7: total of one gives one busy cycle, no strobe (skip both later phases)
    req_cyc = 8'd1;
    @(negedge clk);
    run_seq(1, 0, 0, -1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule